// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit is the interrupt and status side of a register-mapped SPI port that has transmit and receive FIFOs. Software sees three small registers: an interrupt mask, a read-only status word, and a receive length setting. Three interrupt sources are tracked: a byte received, a byte transmitted, and a block transfer finished. Each source has a flag that stays set until software writes a one to it. The unit drives a single interrupt line.

The unit also keeps one sticky FIFO error bit. It is set when the transmit FIFO is popped while empty, or when the receive FIFO is pushed while full. The live empty and full levels are shown next to the error bit, so software can tell which of the two faults happened. Only a FIFO initialisation pulse clears the error bit.

The receive side includes a small bit assembler. It collects serial bits, most significant first, into frames of 1 to 8 bits. A short frame is delivered right-aligned, with its upper bits zero-filled. The serial shifter and the FIFO storage themselves are outside the unit.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset, the mask, the flags, the error bit and the receive length are all 0, `irq` is 0 and `reg_rdata` is 0.
- R2: The mask register sits at address 0. Bit 2 enables the receive interrupt, bit 1 the transmit interrupt and bit 0 the transfer interrupt. A 1 enables the source. Bits written above bit 2 are dropped and always read back as 0.
- R3: The status register sits at address 1. A one-cycle `ev_tx_byte` or `ev_xfr_done` strobe sets status bit 1 or bit 0 at the next clock edge. A completed receive frame sets bit 2 at the edge that ends the frame. A flag holds until a write to address 1 has a 1 in its position. If a set and a clear hit the same flag in one cycle, the set wins.
- R4: `irq` is 1 exactly when some status flag and its mask bit are both 1, judged on the register values after each clock edge.
- R5: Status bit 7 (the error bit) becomes 1 at the edge after a cycle in which `tx_pop` is high while `tx_empty` is high, or `rx_push` is high while `rx_full` is high. If both happen in one cycle, the bit is simply set.
- R6: The error bit is not changed by writes to the status register. It stays set until a cycle with `fifo_init` high clears it at the next edge. If `fifo_init` and an error event share a cycle, the clear wins.
- R7: Status bit 4 shows the `tx_empty` input and status bit 5 shows the `rx_full` input, both sampled in the read cycle. Read with bit 7, they tell a transmit underflow from a receive overflow.
- R8: The receive length register sits at address 2, bits 2:0. A value of 0 selects 8-bit frames. Values 1 to 7 select frames of exactly that many bits. The register reads back as written.
- R9: Each cycle with `rx_bit_valid` high shifts `rx_bit` in, most significant bit first. At the edge that takes the last bit of a frame, `rx_byte_data` is loaded with the frame right-aligned and zero-filled above it. `rx_byte_valid` is then high for that one cycle.
- R10: Register reads take one cycle. `reg_rdata` carries the value selected in the cycle `reg_rd` was high, and is 0 in every other cycle. Unused bits and address 3 read as 0.
- R11: `fifo_init` drops any partly collected receive frame, so the next bit starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 mask, 1 status, 2 receive length, 3 unused |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after `reg_rd` |
| ev_tx_byte | input | 1 | One-cycle pulse: a byte was transmitted |
| ev_xfr_done | input | 1 | One-cycle pulse: a block transfer finished |
| tx_pop | input | 1 | Transmit FIFO pop |
| tx_empty | input | 1 | Transmit FIFO empty level |
| rx_push | input | 1 | Receive FIFO push |
| rx_full | input | 1 | Receive FIFO full level |
| fifo_init | input | 1 | FIFO initialisation pulse |
| rx_bit_valid | input | 1 | A serial receive bit is present |
| rx_bit | input | 1 | Serial receive bit value |
| rx_byte_data | output | FRAME_W | Last completed receive frame, right-aligned |
| rx_byte_valid | output | 1 | One-cycle pulse: a receive frame completed |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle strobes sampled at the clock edge. They also assume that `reg_rd` is low during reset, and that the receive length is not rewritten while a frame is being collected. If the length changes mid-frame, the alignment check would compare against the wrong width. The directed part of the stimulus changes the length only between frames, after a `fifo_init` or a completed frame. The random part never writes address 2 but mixes strobes, level changes, initialisation pulses and mask or status writes freely. In both parts a behavioural model is compared with the outputs on every cycle.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_RXLEN = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Interrupt source positions (shared by mask and status)
  localparam int SRC_XFR = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_RX  = 2;
  localparam int N_SRC   = 3;

  // Status-only positions
  localparam int ST_TXEMPTY = 4;
  localparam int ST_RXFULL  = 5;
  localparam int ST_ERR     = 7;

  // Number of bits in one receive frame for a length setting
  function automatic int rx_target(input int len, input int frame);
    return (len == 0) ? frame : len;
  endfunction

  // Next interrupt flag state: sets win over clears
  function automatic logic [N_SRC-1:0] flag_next(input logic [N_SRC-1:0] cur,
                                                 input logic [N_SRC-1:0] set,
                                                 input logic [N_SRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/spi_rx_frame.sv
module spi_rx_frame #(
  parameter int FRAME_W = 8,
  localparam int LEN_W = $clog2(FRAME_W),
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic [LEN_W-1:0]   len,
  input  logic               bit_valid,
  input  logic               bit_in,
  output logic               done,
  output logic [FRAME_W-1:0] data_q,
  output logic               valid_q
);
  import spi_stat_pkg::*;

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] sh_next;
  logic [CNT_W-1:0]   target;

  assign target  = CNT_W'(rx_target(int'(len), FRAME_W));
  assign sh_next = {sh_q[FRAME_W-2:0], bit_in};
  assign done    = bit_valid && !init && ((cnt_q + CNT_W'(1)) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done;
      if (init) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (done) begin
        cnt_q  <= '0;
        sh_q   <= '0;
        data_q <= sh_next;
      end else if (bit_valid) begin
        cnt_q <= cnt_q + CNT_W'(1);
        sh_q  <= sh_next;
      end
    end
  end

endmodule

// File: rtl/spi_irq_flags.sv
module spi_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags_q,
  output logic         irq
);
  import spi_stat_pkg::*;

  logic [N-1:0] flags_d;

  assign flags_d = flag_next(flags_q, set, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign irq = |(flags_q & en);

endmodule

// File: rtl/spi_fifo_err.sv
module spi_fifo_err (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic tx_pop,
  input  logic tx_empty,
  input  logic rx_push,
  input  logic rx_full,
  output logic err_evt,
  output logic err_q
);

  assign err_evt = (tx_pop && tx_empty) || (rx_push && rx_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (init)    err_q <= 1'b0;
    else if (err_evt) err_q <= 1'b1;
  end

endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq #(
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 8,
  localparam int ADDR_W = 2,
  localparam int LEN_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               ev_tx_byte,
  input  logic               ev_xfr_done,
  input  logic               tx_pop,
  input  logic               tx_empty,
  input  logic               rx_push,
  input  logic               rx_full,
  input  logic               fifo_init,
  input  logic               rx_bit_valid,
  input  logic               rx_bit,
  output logic [FRAME_W-1:0] rx_byte_data,
  output logic               rx_byte_valid,
  output logic               irq
);
  import spi_stat_pkg::*;

  reg_sel_e          sel;
  logic [N_SRC-1:0]  mask_q;
  logic [LEN_W-1:0]  len_q;
  logic [N_SRC-1:0]  flags;
  logic [N_SRC-1:0]  flag_set;
  logic [N_SRC-1:0]  flag_clr;
  logic              rx_done;
  logic              err;
  logic              err_evt;
  logic              wr_mask, wr_stat, wr_len;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign sel     = reg_sel_e'(reg_addr);
  assign wr_mask = reg_wr && (sel == SEL_MASK);
  assign wr_stat = reg_wr && (sel == SEL_STAT);
  assign wr_len  = reg_wr && (sel == SEL_RXLEN);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[N_SRC-1:0];
      if (wr_len)  len_q  <= reg_wdata[LEN_W-1:0];
    end
  end

  spi_rx_frame #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .init(fifo_init), .len(len_q),
    .bit_valid(rx_bit_valid), .bit_in(rx_bit), .done(rx_done),
    .data_q(rx_byte_data), .valid_q(rx_byte_valid)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[SRC_RX]  = rx_done;
    flag_set[SRC_TX]  = ev_tx_byte;
    flag_set[SRC_XFR] = ev_xfr_done;
    flag_clr          = wr_stat ? reg_wdata[N_SRC-1:0] : '0;
  end

  spi_irq_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
    .en(mask_q), .flags_q(flags), .irq(irq)
  );

  spi_fifo_err u_err (
    .clk(clk), .rst_n(rst_n), .init(fifo_init), .tx_pop(tx_pop),
    .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full),
    .err_evt(err_evt), .err_q(err)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASK:  rd_mux[N_SRC-1:0] = mask_q;
      SEL_STAT: begin
        rd_mux[N_SRC-1:0]  = flags;
        rd_mux[ST_TXEMPTY] = tx_empty;
        rd_mux[ST_RXFULL]  = rx_full;
        rd_mux[ST_ERR]     = err;
      end
      SEL_RXLEN: rd_mux[LEN_W-1:0] = len_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= reg_rd ? rd_mux : '0;
  end

endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk #(
  parameter int DATA_W  = 16,
  parameter int FRAME_W = 8,
  localparam int LEN_W  = $clog2(FRAME_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [2:0]         flag_set,
  input logic [2:0]         flags,
  input logic [2:0]         mask,
  input logic               irq,
  input logic               err,
  input logic               err_evt,
  input logic               fifo_init,
  input logic [LEN_W-1:0]   len,
  input logic               rx_valid,
  input logic [FRAME_W-1:0] rx_data
);
  import spi_stat_pkg::*;

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 3'b000) |=> ((flags & $past(flag_set)) == $past(flag_set)));

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & mask) != 3'b000));

  assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & mask) != 3'b000) |-> irq);

  assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !fifo_init) |=> err);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !fifo_init) |=> err);

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_init |=> !err);

  assert_rx_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> rx_target(int'($past(len)), FRAME_W)) == '0));

  assert_rx_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> flags[SRC_RX]);

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> 8) == '0);

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> (reg_rdata == '0));

endmodule

bind spi_stat_irq spi_stat_irq_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .flag_set(flag_set), .flags(flags), .mask(mask_q), .irq(irq),
  .err(err), .err_evt(err_evt), .fifo_init(fifo_init), .len(len_q),
  .rx_valid(rx_byte_valid), .rx_data(rx_byte_data)
);

// File: tb/spi_stat_irq_tb.sv
`timescale 1ns/1ps
module spi_stat_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev_tx_byte = 0, ev_xfr_done = 0, tx_pop = 0, tx_empty = 0;
  logic        rx_push = 0, rx_full = 0, fifo_init = 0, rx_bit_valid = 0, rx_bit = 0;
  logic [7:0]  rx_byte_data;
  logic        rx_byte_valid, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  int en_m = 0, flags_m = 0, err_m = 0, len_m = 0, cnt_m = 0, sh_m = 0, rxd_m = 0, rd_m = 0;
  bit rxv_m = 0, irq_m = 0;

  always #2 clk = ~clk;

  spi_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_tx_byte(ev_tx_byte),
    .ev_xfr_done(ev_xfr_done), .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push),
    .rx_full(rx_full), .fifo_init(fifo_init), .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
    .rx_byte_data(rx_byte_data), .rx_byte_valid(rx_byte_valid), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    int nxt_rd, nb, clr;
    bit ev_rx;
    nxt_rd = 0;
    if (reg_rd) begin
      case (reg_addr)
        2'd0: nxt_rd = en_m;
        2'd1: nxt_rd = flags_m | (err_m << 7) | (int'(rx_full) << 5) | (int'(tx_empty) << 4);
        2'd2: nxt_rd = len_m;
        default: nxt_rd = 0;
      endcase
    end
    rxv_m = 0; ev_rx = 0;
    if (fifo_init) begin
      cnt_m = 0; sh_m = 0;
    end else if (rx_bit_valid) begin
      sh_m = ((sh_m << 1) | int'(rx_bit)) & 255;
      cnt_m++;
      nb = (len_m == 0) ? 8 : len_m;
      if (cnt_m == nb) begin
        rxv_m = 1; ev_rx = 1; rxd_m = sh_m; cnt_m = 0; sh_m = 0;
      end
    end
    clr = (reg_wr && reg_addr == 2'd1) ? (int'(reg_wdata) & 7) : 0;
    flags_m = (flags_m & ~clr & 7) | (int'(ev_rx) << 2) | (int'(ev_tx_byte) << 1) | int'(ev_xfr_done);
    if (reg_wr && reg_addr == 2'd0) en_m = int'(reg_wdata) & 7;
    if (reg_wr && reg_addr == 2'd2) len_m = int'(reg_wdata) & 7;
    if (fifo_init) err_m = 0;
    else if ((tx_pop && tx_empty) || (rx_push && rx_full)) err_m = 1;
    rd_m = nxt_rd;
    irq_m = (flags_m & en_m) != 0;
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(irq == irq_m, "R4 irq", int'(irq), int'(irq_m));
    chk(int'(reg_rdata) == rd_m, "R10 reg_rdata", int'(reg_rdata), rd_m);
    chk(rx_byte_valid == rxv_m, "R9 rx_byte_valid", int'(rx_byte_valid), int'(rxv_m));
    chk(int'(rx_byte_data) == rxd_m, "R9 rx_byte_data", int'(rx_byte_data), rxd_m);
    ev_tx_byte = 0; ev_xfr_done = 0; tx_pop = 0; rx_push = 0; fifo_init = 0;
    rx_bit_valid = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = 2'(a); reg_wdata = 16'(d); reg_wr = 1; step();
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_addr = 2'(a); reg_rd = 1; step();
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic send(input int val, input int n, input int exp, input string tag);
    for (int i = n - 1; i >= 0; i--) begin
      rx_bit_valid = 1; rx_bit = val[i]; step();
    end
    chk(rx_byte_valid && int'(rx_byte_data) == exp, tag, int'(rx_byte_data), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(irq == 0 && reg_rdata == 0 && rx_byte_valid == 0, "R1 reset outputs", int'(irq), 0);
    rst_n = 1;
    step();
    rd(0, 16'h0000, "R1 mask reset");
    rd(1, 16'h0000, "R1 status reset");
    rd(2, 16'h0000, "R1 rxlen reset");
    // R2 mask with reserved bits written
    wr(0, 16'hFFFF);
    rd(0, 16'h0007, "R2 mask readback");
    // R3 transmit flag, R4 irq
    ev_tx_byte = 1; step();
    chk(irq == 1, "R4 irq on tx flag", int'(irq), 1);
    rd(1, 16'h0002, "R3 tx flag set");
    wr(1, 16'h0002);
    chk(irq == 0, "R4 irq after clear", int'(irq), 0);
    rd(1, 16'h0000, "R3 tx flag cleared");
    // R4 masked source
    wr(0, 16'h0000);
    ev_xfr_done = 1; step();
    chk(irq == 0, "R4 masked xfr", int'(irq), 0);
    // R3 set wins over clear
    ev_xfr_done = 1; reg_addr = 2'd1; reg_wdata = 16'h0001; reg_wr = 1; step();
    rd(1, 16'h0001, "R3 set wins");
    wr(1, 16'h0007);
    // R5 underflow, R7 live levels
    tx_empty = 1; tx_pop = 1; step();
    rd(1, 16'h0090, "R5 R7 underflow view");
    wr(1, 16'hFFFF);
    rd(1, 16'h0090, "R6 err survives status write");
    fifo_init = 1; step();
    rd(1, 16'h0010, "R6 err cleared by init");
    tx_empty = 0; rx_full = 1; rx_push = 1; fifo_init = 1; step();
    rd(1, 16'h0020, "R6 init wins over event");
    rx_push = 1; step();
    rd(1, 16'h00A0, "R5 R7 overflow view");
    fifo_init = 1; rx_full = 0; step();
    // R8 R9 frames
    wr(0, 16'h0004);
    send(8'hA5, 8, 8'hA5, "R9 full byte");
    chk(irq == 1, "R3 rx flag drives irq", int'(irq), 1);
    rd(1, 16'h0004, "R3 rx flag set");
    wr(1, 16'h0004);
    wr(2, 3);
    rd(2, 3, "R8 rxlen readback");
    send(3'b101, 3, 8'h05, "R8 three-bit frame");
    wr(2, 1);
    send(1, 1, 8'h01, "R8 one-bit frame");
    wr(2, 7);
    send(7'h5B, 7, 8'h5B, "R8 seven-bit frame");
    // R11 init drops partial frame
    wr(2, 0);
    for (int i = 0; i < 4; i++) begin rx_bit_valid = 1; rx_bit = 1; step(); end
    fifo_init = 1; step();
    send(8'h3C, 8, 8'h3C, "R11 fresh frame after init");
    rd(3, 0, "R10 unused address");
    // random phase, length fixed
    for (int c = 0; c < 4000; c++) begin
      reg_addr = 2'($urandom % 4);
      reg_wr = ($urandom % 6 == 0) && reg_addr != 2'd2;
      reg_rd = ($urandom % 3 == 0);
      reg_wdata = 16'($urandom);
      ev_tx_byte = ($urandom % 5 == 0); ev_xfr_done = ($urandom % 7 == 0);
      tx_pop = ($urandom % 4 == 0); rx_push = ($urandom % 4 == 0);
      tx_empty = ($urandom % 3 == 0); rx_full = ($urandom % 3 == 0);
      fifo_init = ($urandom % 40 == 0);
      rx_bit_valid = ($urandom % 2 == 0); rx_bit = 1'($urandom);
      step();
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule